// File: doc/BRIEF.md
# Sleep Mode Entry/Wake Controller

This block moves a processor core into a light sleep state and brings it back out. It watches a strobe from the core that marks a sleep request. It also watches a standby-select bit held in a small control register. When the request is accepted, the block drops the core clock enable. The peripheral clock enable stays high, so the on-chip modules keep running while the core is halted. Core register contents are kept simply because the core receives no clock.

While the core sleeps, the block watches four kinds of wake event:

- an interrupt request, qualified by its source enable and by comparing its priority against the core's mask level;
- a DMA address-error flag;
- the external reset pin;
- edges on the NMI pin, whose polarity is chosen by a bit in the control register.

On wake, the block raises the core clock enable again. In that same cycle it presents a one-cycle pulse with a 2-bit code naming the exit path.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: A sleep strobe sampled in the run state while the standby bit (control register bit 7) is 0 puts the block asleep from the next cycle: `asleep` goes to 1 and `core_clk_en` goes to 0.
- R2: A sleep strobe sampled while the standby bit is 1 leaves the block awake.
- R3: For the whole time the block is asleep, `periph_clk_en` stays 1 and `core_clk_en` stays 0.
- R4: An interrupt request wakes the block only if its source enable is 1 and its level is strictly greater than `mask_level`. An equal or lower level, or a disabled source, leaves the block asleep. An interrupt wake reports cause code 00.
- R5: A DMA address error sampled while asleep wakes the block with cause code 01.
- R6: The reset pin sampled low while asleep wakes the block. The cause code is 10 (power-on reset) if the synchronised NMI level is high, and 11 (manual reset) if it is low.
- R7: NMI passes through a two-flop synchroniser. While asleep, an NMI edge of the polarity chosen by control bit 6 (1 = rising, 0 = falling) wakes the block with cause code 00, three clock edges after the pin changes. The opposite edge does not wake it.
- R8: Control register readback: bit 7 is the standby bit and bit 6 is the NMI edge select, both writable and reset to 0. Bit 5 always reads 0 whatever is written. Bits 4 to 0 always read 1.
- R9: When wake events coincide, reset takes precedence over a DMA error, and a DMA error takes precedence over an interrupt or NMI.
- R10: The exit pulse `exit_valid` lasts exactly one cycle, with `core_clk_en` already 1. The block is in the run state afterwards, and a sleep strobe that arrives during the exit cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_strobe | input | 1 | One-cycle sleep request from the core |
| irq_valid | input | 1 | An interrupt request is pending |
| irq_level | input | 4 | Priority level of the pending interrupt |
| irq_src_en | input | 1 | Source module enables the pending interrupt |
| mask_level | input | 4 | Core interrupt mask level |
| dma_addr_err | input | 1 | DMA address-error flag |
| reset_pin_n | input | 1 | External reset pin, synchronous, active low |
| nmi_pin | input | 1 | Asynchronous NMI pin |
| reg_wr | input | 1 | Control register write enable |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| asleep | output | 1 | Block is in the sleep state |
| exit_valid | output | 1 | One-cycle wake pulse |
| exit_cause | output | 2 | Wake cause: 00 interrupt/NMI, 01 DMA error, 10 power-on reset, 11 manual reset |

## Verification
The assertions check on every cycle that:

- sleep is entered or refused according to the standby bit;
- clock enables are held correctly while asleep;
- a non-qualifying cycle never ends sleep;
- DMA and reset wakes carry their codes and precedence;
- the exit pulse lasts exactly one cycle;
- the fixed bits read back correctly.

Other behaviour only the bench scenarios can show:

- the three-edge latency through the NMI synchroniser;
- refusal of the opposite NMI edge;
- the strict priority comparison at the equal-level boundary;
- the reset type chosen from the NMI level held before reset;
- the strobe ignored during the exit cycle.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_SLEEP = 2'b01,
        ST_WAKE  = 2'b10
    } swc_state_e;

    typedef enum logic [1:0] {
        CAUSE_IRQ    = 2'b00,
        CAUSE_DMAERR = 2'b01,
        CAUSE_POR    = 2'b10,
        CAUSE_MRST   = 2'b11
    } swc_cause_e;

    localparam int CTL_W        = 8;
    localparam int CTL_STBY_BIT = 7;
    localparam int CTL_EDGE_BIT = 6;

    typedef struct packed {
        swc_state_e st;
        swc_cause_e cause;
    } swc_fsm_t;
endpackage

// File: rtl/swc_nmi_sync.sv
module swc_nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic level,
    output logic edge_hit
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.chain[0] = pin;
        for (int i = 1; i < STAGES; i++) begin
            s_d.chain[i] = s_q.chain[i-1];
        end
        s_d.prev = s_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level    = s_q.chain[LAST];
    assign edge_hit = rise_sel ? (level && !s_q.prev) : (!level && s_q.prev);
endmodule

// File: rtl/swc_wake_arb.sv
module swc_wake_arb
    import swc_pkg::*;
#(
    parameter int PRIO_W = 4
) (
    input  logic              irq_valid,
    input  logic [PRIO_W-1:0] irq_level,
    input  logic              irq_src_en,
    input  logic [PRIO_W-1:0] mask_level,
    input  logic              dma_addr_err,
    input  logic              reset_pin_n,
    input  logic              nmi_level,
    input  logic              nmi_edge_hit,
    output logic              wake,
    output swc_cause_e        cause
);
    logic irq_ok;

    assign irq_ok = irq_valid && irq_src_en && (irq_level > mask_level);

    always_comb begin
        wake  = 1'b1;
        cause = CAUSE_IRQ;
        if (!reset_pin_n)               cause = nmi_level ? CAUSE_POR : CAUSE_MRST;
        else if (dma_addr_err)          cause = CAUSE_DMAERR;
        else if (irq_ok || nmi_edge_hit) cause = CAUSE_IRQ;
        else                            wake  = 1'b0;
    end
endmodule

// File: rtl/swc_ctl_reg.sv
module swc_ctl_reg
    import swc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    output logic             stby,
    output logic             rise_sel
);
    typedef struct packed {
        logic stby;
        logic rise;
    } ctl_t;

    ctl_t c_d, c_q;
    logic unused_wbits;

    assign unused_wbits = ^wdata[CTL_EDGE_BIT-1:0];

    always_comb begin
        c_d = c_q;
        if (wr) begin
            c_d.stby = wdata[CTL_STBY_BIT];
            c_d.rise = wdata[CTL_EDGE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign stby     = c_q.stby;
    assign rise_sel = c_q.rise;
    assign rdata    = {c_q.stby, c_q.rise, 1'b0, {(CTL_EDGE_BIT-1){1'b1}}};
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
    import swc_pkg::*;
#(
    parameter int PRIO_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_strobe,
    input  logic              irq_valid,
    input  logic [PRIO_W-1:0] irq_level,
    input  logic              irq_src_en,
    input  logic [PRIO_W-1:0] mask_level,
    input  logic              dma_addr_err,
    input  logic              reset_pin_n,
    input  logic              nmi_pin,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              core_clk_en,
    output logic              periph_clk_en,
    output logic              asleep,
    output logic              exit_valid,
    output logic [1:0]        exit_cause
);
    logic       stby, rise_sel;
    logic       nmi_level, nmi_edge_hit;
    logic       wake;
    swc_cause_e wake_cause;
    swc_fsm_t   f_d, f_q;

    swc_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .stby     (stby),
        .rise_sel (rise_sel)
    );

    swc_nmi_sync #(.STAGES(SYNC_STAGES)) u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (nmi_pin),
        .rise_sel (rise_sel),
        .level    (nmi_level),
        .edge_hit (nmi_edge_hit)
    );

    swc_wake_arb #(.PRIO_W(PRIO_W)) u_arb (
        .irq_valid    (irq_valid),
        .irq_level    (irq_level),
        .irq_src_en   (irq_src_en),
        .mask_level   (mask_level),
        .dma_addr_err (dma_addr_err),
        .reset_pin_n  (reset_pin_n),
        .nmi_level    (nmi_level),
        .nmi_edge_hit (nmi_edge_hit),
        .wake         (wake),
        .cause        (wake_cause)
    );

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            ST_RUN: begin
                if (sleep_strobe && !stby) f_d.st = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake) begin
                    f_d.st    = ST_WAKE;
                    f_d.cause = wake_cause;
                end
            end
            ST_WAKE:  f_d.st = ST_RUN;
            default:  f_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_RUN, cause: CAUSE_IRQ};
        else        f_q <= f_d;
    end

    assign asleep        = (f_q.st == ST_SLEEP);
    assign core_clk_en   = !asleep;
    assign periph_clk_en = 1'b1;
    assign exit_valid    = (f_q.st == ST_WAKE);
    assign exit_cause    = f_q.cause;
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
    parameter int PRIO_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_strobe,
    input logic              irq_valid,
    input logic [PRIO_W-1:0] irq_level,
    input logic              irq_src_en,
    input logic [PRIO_W-1:0] mask_level,
    input logic              dma_addr_err,
    input logic              reset_pin_n,
    input logic              nmi_level,
    input logic              nmi_edge_hit,
    input logic [7:0]        reg_rdata,
    input logic              core_clk_en,
    input logic              periph_clk_en,
    input logic              asleep,
    input logic              exit_valid,
    input logic [1:0]        exit_cause
);
    AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && !exit_valid && sleep_strobe && !reg_rdata[7]) |=> (asleep && !core_clk_en)); // R1
    AST_STBY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && sleep_strobe && reg_rdata[7]) |=> !asleep); // R2
    AST_SLEEP_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> (periph_clk_en && !core_clk_en)); // R3
    AST_NO_SPURIOUS_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && reset_pin_n && !dma_addr_err && !nmi_edge_hit &&
         !(irq_valid && irq_src_en && (irq_level > mask_level))) |=> asleep); // R4
    AST_DMA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && reset_pin_n && dma_addr_err) |=> (exit_valid && exit_cause == 2'b01)); // R5
    AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !reset_pin_n) |=> (exit_valid && exit_cause == ($past(nmi_level) ? 2'b10 : 2'b11))); // R6
    AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5:0] == 6'b011111); // R8
    AST_EXIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |=> (!exit_valid && !asleep)); // R10
    AST_EXIT_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> (core_clk_en && !asleep)); // R10
endmodule

bind sleep_wake_ctrl swc_checker #(.PRIO_W(PRIO_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sleep_strobe (sleep_strobe),
    .irq_valid    (irq_valid),
    .irq_level    (irq_level),
    .irq_src_en   (irq_src_en),
    .mask_level   (mask_level),
    .dma_addr_err (dma_addr_err),
    .reset_pin_n  (reset_pin_n),
    .nmi_level    (nmi_level),
    .nmi_edge_hit (nmi_edge_hit),
    .reg_rdata    (reg_rdata),
    .core_clk_en  (core_clk_en),
    .periph_clk_en(periph_clk_en),
    .asleep       (asleep),
    .exit_valid   (exit_valid),
    .exit_cause   (exit_cause)
);

// File: tb/tb_sleep_wake_ctrl.sv
module tb_sleep_wake_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_strobe = 1'b0;
    logic       irq_valid = 1'b0;
    logic [3:0] irq_level = '0;
    logic       irq_src_en = 1'b1;
    logic [3:0] mask_level = '0;
    logic       dma_addr_err = 1'b0;
    logic       reset_pin_n = 1'b1;
    logic       nmi_pin = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       core_clk_en, periph_clk_en, asleep, exit_valid;
    logic [1:0] exit_cause;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_q[$];
    logic [7:0] label_q[$];

    sleep_wake_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: each exit pulse is matched against the expected cause
    always @(negedge clk) begin
        if (rst_n && exit_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected exit", int'(exit_cause), 0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                chk(exit_cause == e, "R4-R9 exit cause", int'(exit_cause), int'(e));
                chk(core_clk_en == 1'b1, "R10 clk on at exit", int'(core_clk_en), 1);
            end
        end
    end

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic enter_sleep();
        @(negedge clk); sleep_strobe = 1'b1;
        @(negedge clk); sleep_strobe = 1'b0;
        chk(asleep == 1'b1 && core_clk_en == 1'b0, "R1 entry", int'(asleep), 1);
        chk(periph_clk_en == 1'b1, "R3 periph on", int'(periph_clk_en), 1);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // push expected cause; the stimulus is sampled at the next edge
    task automatic expect_exit(input logic [1:0] c);
        exp_q.push_back(c);
    endtask

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        chk(asleep == 1'b0 && core_clk_en == 1'b1 && exit_valid == 1'b0, "R1 reset state", int'(asleep), 0);
        chk(reg_rdata == 8'h1F, "R8 reset readback", int'(reg_rdata), 8'h1F);

        // R8 register field behaviour
        write_reg(8'hFF);
        chk(reg_rdata == 8'hDF, "R8 write ones", int'(reg_rdata), 8'hDF);
        write_reg(8'h20);
        chk(reg_rdata == 8'h1F, "R8 bit5 ignored", int'(reg_rdata), 8'h1F);

        // R2 standby bit blocks entry
        write_reg(8'h80);
        @(negedge clk); sleep_strobe = 1'b1;
        @(negedge clk); sleep_strobe = 1'b0;
        chk(asleep == 1'b0 && core_clk_en == 1'b1, "R2 standby blocks", int'(asleep), 0);
        idle(2);
        chk(asleep == 1'b0, "R2 still awake", int'(asleep), 0);
        write_reg(8'h00);

        // R4 equal priority does not wake, higher does
        enter_sleep();
        @(negedge clk); irq_valid = 1'b1; irq_level = 4'd3; mask_level = 4'd3;
        idle(3);
        chk(asleep == 1'b1, "R4 equal level stays asleep", int'(asleep), 1);
        irq_level = 4'd2;
        idle(2);
        chk(asleep == 1'b1 && core_clk_en == 1'b0, "R3 R4 lower level asleep", int'(asleep), 1);
        expect_exit(2'b00); irq_level = 4'd4;
        @(negedge clk); irq_valid = 1'b0;
        chk(exit_valid == 1'b1, "R4 higher level wakes", int'(exit_valid), 1);
        @(negedge clk);
        chk(exit_valid == 1'b0 && asleep == 1'b0, "R10 one-cycle pulse", int'(exit_valid), 0);

        // R4 disabled source never wakes; R5 DMA error wakes
        enter_sleep();
        @(negedge clk); irq_valid = 1'b1; irq_level = 4'd9; mask_level = 4'd2; irq_src_en = 1'b0;
        idle(3);
        chk(asleep == 1'b1, "R4 disabled source", int'(asleep), 1);
        expect_exit(2'b01); dma_addr_err = 1'b1;
        @(negedge clk); dma_addr_err = 1'b0; irq_valid = 1'b0; irq_src_en = 1'b1;
        chk(exit_valid == 1'b1, "R5 dma wake", int'(exit_valid), 1);
        // R10 strobe in exit cycle ignored
        sleep_strobe = 1'b1;
        @(negedge clk); sleep_strobe = 1'b0;
        chk(asleep == 1'b0, "R10 strobe ignored in exit", int'(asleep), 0);

        // R7 rising select: rising wakes after three edges, falling does not
        write_reg(8'h40);
        enter_sleep();
        @(negedge clk); nmi_pin = 1'b1; expect_exit(2'b00);
        idle(2);
        chk(asleep == 1'b1, "R7 sync latency", int'(asleep), 1);
        @(negedge clk);
        chk(exit_valid == 1'b1, "R7 rising nmi wakes", int'(exit_valid), 1);
        idle(4);
        enter_sleep();
        @(negedge clk); nmi_pin = 1'b0;
        idle(5);
        chk(asleep == 1'b1, "R7 opposite edge ignored", int'(asleep), 1);
        // R6 manual reset with nmi low
        expect_exit(2'b11); reset_pin_n = 1'b0;
        @(negedge clk); reset_pin_n = 1'b1;
        chk(exit_valid == 1'b1, "R6 manual reset wake", int'(exit_valid), 1);

        // R7 falling select
        write_reg(8'h00);
        enter_sleep();
        @(negedge clk); nmi_pin = 1'b1;
        idle(5);
        chk(asleep == 1'b1, "R7 rise ignored when falling sel", int'(asleep), 1);
        expect_exit(2'b00); nmi_pin = 1'b0;
        idle(3);
        chk(exit_valid == 1'b1, "R7 falling nmi wakes", int'(exit_valid), 1);

        // R6 power-on reset with nmi high (rising select so the setup edge is ignored? no: falling sel, rise ignored)
        @(negedge clk); nmi_pin = 1'b1;
        idle(4);
        enter_sleep();
        expect_exit(2'b10); reset_pin_n = 1'b0; dma_addr_err = 1'b1;
        @(negedge clk); reset_pin_n = 1'b1; dma_addr_err = 1'b0;
        chk(exit_valid == 1'b1, "R6 R9 por over dma", int'(exit_valid), 1);

        // R9 dma over interrupt
        idle(2);
        enter_sleep();
        expect_exit(2'b01); dma_addr_err = 1'b1; irq_valid = 1'b1; irq_level = 4'd15; mask_level = 4'd0;
        @(negedge clk); dma_addr_err = 1'b0; irq_valid = 1'b0;
        chk(exit_valid == 1'b1, "R9 dma over irq", int'(exit_valid), 1);
        idle(3);

        chk(exp_q.size() == 0, "R10 all exits seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule